// File: doc/BRIEF.md
# Pattern Generator and Bit Error Rate Tester

This block generates a serial test stream and checks a serial test stream. The stream is either a pseudo-random sequence or a repeating word of 1 to 32 bits. The transmit side produces one new bit for each cycle in which its enable is high. On request it inverts a single bit, or it inverts bits at a fixed rate of one in 10^n.

The receive side locks onto the incoming bits. It compares each enabled bit with the bit it predicts. While locked, it adds each mismatch to a wide error counter that saturates. The counter is read by strobing a latch input. That copies the live count to the output register and restarts the live count in the same cycle.

The surrounding framer decides which stream positions carry test data. It does this by driving the two enables. If the enables are held high, the whole stream carries the pattern.

Top module: `bert_core`

## Requirements
- R1: With patSel = 0 the transmit stream is the 2^15-1 sequence x^15+x^14+1. Each new bit is the XOR of the bits 15 and 14 positions earlier in the stream. The stream starts from an all-ones history after reset. Each bit appears on txBit the cycle after the enabled edge.
- R2: With patSel = 1 the stream is the 2^23-1 sequence x^23+x^18+1. Each new bit is the XOR of the bits 23 and 18 positions earlier. The history is all ones after reset.
- R3: With patSel = 2 or 3 the stream repeats userPat[0], userPat[1] and so on up to userPat[userLen], then starts again. Bit 0 goes first, and the period is userLen+1 (1 to 32). The checker aligns to any phase of the same word.
- R4: A one-cycle pulse on injOne inverts exactly one bit: the next enabled transmit bit, or the current one if txEn is high in the same cycle.
- R5: With rateSel = n (1..7), every 10^n-th enabled transmit bit after reset is inverted. rateSel = 0 disables rate injection.
- R6: Out of sync, the checker sets inSync the cycle after the 32nd consecutive enabled receive bit that matches its prediction.
- R7: In sync, the receive bits are grouped into 64-bit windows, starting at the first bit after sync is gained. The 6th error inside one window clears inSync. Errors split across two windows never do.
- R8: Errors add to the live count only while inSync is high. The bit that causes loss of sync is still counted. Mismatches while hunting add nothing.
- R9: The live count stops at all ones (2^24-1 by default) and never wraps.
- R10: A latchStrb cycle loads errCount with the live count. The live count restarts at the error of that same cycle (1 if that bit is in error, else 0), so no error is lost.
- R11: Transmit and receive state move only on their enables. txBit holds its value, and the checker state is unchanged, in cycles without enable.
- R12: During and after reset, txBit, inSync and errCount are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| patSel | input | 2 | 0: 2^15-1, 1: 2^23-1, 2/3: user word |
| userPat | input | PAT_W | Repeating word, bit 0 sent first |
| userLen | input | LEN_W | Word length minus one |
| txEn | input | 1 | Transmit payload enable |
| injOne | input | 1 | Single error request pulse |
| rateSel | input | 3 | Rate injection exponent, 0 off |
| txBit | output | 1 | Generated bit, registered |
| rxEn | input | 1 | Receive payload enable |
| rxBit | input | 1 | Received bit |
| latchStrb | input | 1 | Copy live count and restart it |
| inSync | output | 1 | Checker locked |
| errCount | output | CNT_W | Latched error count |

## Verification
Sync acquisition is checked at the exact bit. The bench looks at inSync after the 31st and after the 32nd clean bit, so an off-by-one in the clean counter is caught. Errors are placed so that a window-based loss rule is told apart from a sliding one: ten consecutive errors that straddle a window edge must keep sync, while six inside one window must drop it on the sixth bit.

A second instance with a 4-bit counter shows whether the counter saturates or wraps. A latch strobe is placed on an erroneous bit to expose a design that drops that error. Rate injection is checked at every 10th and every 100th bit, which catches an off-by-one in the interval.

// File: rtl/bert_pkg.sv
package bert_pkg;

  localparam int LFSR_W = 23;
  localparam int RATE_W = 24;

  typedef enum logic [1:0] {
    PAT_PRBS15   = 2'd0,
    PAT_PRBS23   = 2'd1,
    PAT_USER     = 2'd2,
    PAT_USER_ALT = 2'd3
  } patMode_e;

  typedef struct packed {
    logic flipTx;    // invert the bit being generated
    logic loadRx;    // hunting: shift received bit into predictor
    logic slip;      // hunting: hold user-word phase on mismatch
    logic countErr;  // add one to the live error count
  } bertCtl_t;

  function automatic logic lfsrFb(input logic [LFSR_W-1:0] s, input patMode_e m);
    return (m == PAT_PRBS23) ? (s[22] ^ s[17]) : (s[14] ^ s[13]);
  endfunction

endpackage

// File: rtl/bert_datapath.sv
module bert_datapath
  import bert_pkg::*;
#(
  parameter int PAT_W = 32,
  parameter int CNT_W = 24,
  parameter int LEN_W = $clog2(PAT_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       patSel,
  input  logic [PAT_W-1:0] userPat,
  input  logic [LEN_W-1:0] userLen,
  input  logic             txEn,
  input  logic             rxEn,
  input  logic             rxBit,
  input  logic             latchStrb,
  input  bertCtl_t         ctl,
  output logic             txBit,
  output logic             errBit,
  output logic [CNT_W-1:0] errCount
);

  patMode_e mode;
  logic     userMode;
  assign mode     = patMode_e'(patSel);
  assign userMode = (mode == PAT_USER) || (mode == PAT_USER_ALT);

  // ---------------- generator ----------------
  logic [LFSR_W-1:0] txLfsr;
  logic [LEN_W-1:0]  txIdx;
  logic              txBitQ;
  logic              genBit;

  assign genBit = userMode ? userPat[txIdx] : lfsrFb(txLfsr, mode);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txLfsr <= '1;
      txIdx  <= '0;
      txBitQ <= 1'b0;
    end else if (txEn) begin
      txBitQ <= genBit ^ ctl.flipTx;
      txLfsr <= {txLfsr[LFSR_W-2:0], lfsrFb(txLfsr, mode)};
      txIdx  <= (txIdx >= userLen) ? '0 : txIdx + 1'b1;
    end
  end

  assign txBit = txBitQ;

  // ---------------- checker prediction ----------------
  logic [LFSR_W-1:0] rxLfsr;
  logic [LEN_W-1:0]  rxIdx;
  logic              expBit;

  assign expBit = userMode ? userPat[rxIdx] : lfsrFb(rxLfsr, mode);
  assign errBit = rxEn & (rxBit ^ expBit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxLfsr <= '1;
      rxIdx  <= '0;
    end else if (rxEn) begin
      rxLfsr <= {rxLfsr[LFSR_W-2:0], ctl.loadRx ? rxBit : expBit};
      if (!ctl.slip)
        rxIdx <= (rxIdx >= userLen) ? '0 : rxIdx + 1'b1;
    end
  end

  // ---------------- error counter ----------------
  logic [CNT_W-1:0] liveCnt;
  logic [CNT_W-1:0] latchQ;
  logic             cntFull;

  assign cntFull = &liveCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      liveCnt <= '0;
      latchQ  <= '0;
    end else if (latchStrb) begin
      latchQ  <= liveCnt;
      liveCnt <= ctl.countErr ? CNT_W'(1) : '0;
    end else if (ctl.countErr && !cntFull) begin
      liveCnt <= liveCnt + 1'b1;
    end
  end

  assign errCount = latchQ;

  // ---------------- assertions ----------------
  p_tx_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !txEn |=> $stable(txBitQ));

  p_saturate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cntFull && !latchStrb) |=> cntFull);

  p_latch_restart_r10: assert property (@(posedge clk) disable iff (!rstN)
    latchStrb |=> (liveCnt <= CNT_W'(1)) && (latchQ == $past(liveCnt)));

  p_hold_unless_counted_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.countErr && !latchStrb) |=> $stable(liveCnt));

endmodule

// File: rtl/bert_control.sv
module bert_control
  import bert_pkg::*;
#(
  parameter int SYNC_CLEAN = 32,
  parameter int WIN_LEN    = 64,
  parameter int LOSS_ERRS  = 6,
  parameter int MAX_EXP    = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEn,
  input  logic       rxEn,
  input  logic       errBit,
  input  logic       injOne,
  input  logic [2:0] rateSel,
  output bertCtl_t   ctl,
  output logic       inSync
);

  localparam int CLEAN_W = $clog2(SYNC_CLEAN + 1);
  localparam int WIN_W   = $clog2(WIN_LEN);
  localparam int WERR_W  = $clog2(LOSS_ERRS + 1);

  // ---------------- sync state ----------------
  logic              inSyncQ;
  logic [CLEAN_W-1:0] cleanCnt;
  logic [WIN_W-1:0]   winCnt;
  logic [WERR_W-1:0]  winErr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inSyncQ  <= 1'b0;
      cleanCnt <= '0;
      winCnt   <= '0;
      winErr   <= '0;
    end else if (rxEn) begin
      if (!inSyncQ) begin
        if (errBit) begin
          cleanCnt <= '0;
        end else if (cleanCnt == CLEAN_W'(SYNC_CLEAN - 1)) begin
          inSyncQ  <= 1'b1;
          cleanCnt <= '0;
          winCnt   <= '0;
          winErr   <= '0;
        end else begin
          cleanCnt <= cleanCnt + 1'b1;
        end
      end else begin
        if (errBit && (winErr == WERR_W'(LOSS_ERRS - 1))) begin
          inSyncQ  <= 1'b0;
          cleanCnt <= '0;
        end else if (winCnt == WIN_W'(WIN_LEN - 1)) begin
          winCnt <= '0;
          winErr <= '0;
        end else begin
          winCnt <= winCnt + 1'b1;
          winErr <= winErr + WERR_W'(errBit);
        end
      end
    end
  end

  assign inSync = inSyncQ;

  // ---------------- error injection ----------------
  function automatic logic [RATE_W-1:0] rateLimit(input logic [2:0] n);
    logic [RATE_W-1:0] v;
    v = RATE_W'(1);
    for (int i = 1; i <= MAX_EXP; i++)
      if (i <= int'(n)) v = v * RATE_W'(10);
    return v - 1'b1;
  endfunction

  logic              pendQ;
  logic [RATE_W-1:0] rateCnt;
  logic              rateOn;
  logic              rateHit;

  assign rateOn  = (rateSel != 3'd0);
  assign rateHit = txEn && rateOn && (rateCnt >= rateLimit(rateSel));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ   <= 1'b0;
      rateCnt <= '0;
    end else begin
      if (txEn)        pendQ <= 1'b0;
      else if (injOne) pendQ <= 1'b1;

      if (!rateOn)   rateCnt <= '0;
      else if (txEn) rateCnt <= rateHit ? '0 : rateCnt + 1'b1;
    end
  end

  always_comb begin
    ctl.flipTx   = txEn & (pendQ | injOne | rateHit);
    ctl.loadRx   = !inSyncQ;
    ctl.slip     = !inSyncQ & errBit;
    ctl.countErr = inSyncQ & errBit;
  end

  // ---------------- assertions ----------------
  p_gain_on_clean_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inSyncQ) |-> ($past(rxEn) && !$past(errBit)));

  p_loss_on_error_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inSyncQ) |-> ($past(rxEn) && $past(errBit)));

  p_single_served_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ && txEn) |=> !pendQ);

  p_win_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    inSyncQ |-> (winErr < WERR_W'(LOSS_ERRS)));

endmodule

// File: rtl/bert_core.sv
module bert_core
  import bert_pkg::*;
#(
  parameter int PAT_W      = 32,
  parameter int CNT_W      = 24,
  parameter int LEN_W      = $clog2(PAT_W),
  parameter int SYNC_CLEAN = 32,
  parameter int WIN_LEN    = 64,
  parameter int LOSS_ERRS  = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       patSel,
  input  logic [PAT_W-1:0] userPat,
  input  logic [LEN_W-1:0] userLen,
  input  logic             txEn,
  input  logic             injOne,
  input  logic [2:0]       rateSel,
  output logic             txBit,
  input  logic             rxEn,
  input  logic             rxBit,
  input  logic             latchStrb,
  output logic             inSync,
  output logic [CNT_W-1:0] errCount
);

  bertCtl_t ctl;
  logic     errBit;

  bert_datapath #(.PAT_W(PAT_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .patSel(patSel), .userPat(userPat),
    .userLen(userLen), .txEn(txEn), .rxEn(rxEn), .rxBit(rxBit),
    .latchStrb(latchStrb), .ctl(ctl), .txBit(txBit), .errBit(errBit),
    .errCount(errCount)
  );

  bert_control #(.SYNC_CLEAN(SYNC_CLEAN), .WIN_LEN(WIN_LEN),
                 .LOSS_ERRS(LOSS_ERRS)) u_ctl (
    .clk(clk), .rstN(rstN), .txEn(txEn), .rxEn(rxEn), .errBit(errBit),
    .injOne(injOne), .rateSel(rateSel), .ctl(ctl), .inSync(inSync)
  );

endmodule

// File: tb/bert_core_tb.sv
`timescale 1ns/1ps
module bert_core_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  patSel = 2'd0;
  logic [31:0] userPat = '0;
  logic [4:0]  userLen = '0;
  logic        txEn = 1'b0, injOne = 1'b0, rxEn = 1'b0, rxBit = 1'b0;
  logic        latchStrb = 1'b0;
  logic [2:0]  rateSel = 3'd0;
  logic        txBit, inSync, txBitS, inSyncS;
  logic [23:0] errCount;
  logic [3:0]  errCountS;

  int checks = 0, errors = 0;
  logic [22:0] mState;

  always #2.5 clk = ~clk;

  bert_core u_dut (
    .clk(clk), .rstN(rstN), .patSel(patSel), .userPat(userPat), .userLen(userLen),
    .txEn(txEn), .injOne(injOne), .rateSel(rateSel), .txBit(txBit),
    .rxEn(rxEn), .rxBit(rxBit), .latchStrb(latchStrb), .inSync(inSync),
    .errCount(errCount));

  bert_core #(.CNT_W(4)) u_small (
    .clk(clk), .rstN(rstN), .patSel(patSel), .userPat(userPat), .userLen(userLen),
    .txEn(txEn), .injOne(injOne), .rateSel(rateSel), .txBit(txBitS),
    .rxEn(rxEn), .rxBit(rxBit), .latchStrb(latchStrb), .inSync(inSyncS),
    .errCount(errCountS));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference sequence from the polynomial definitions (R1, R2)
  task automatic mStep(input logic p23, output logic b);
    b = p23 ? (mState[22] ^ mState[17]) : (mState[14] ^ mState[13]);
    mState = {mState[21:0], b};
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; txEn = 0; rxEn = 0; injOne = 0; latchStrb = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mState = '1;
  endtask

  task automatic txStep(output logic b);
    txEn = 1'b1;
    @(negedge clk);
    txEn = 1'b0;
    b = txBit;
  endtask

  task automatic rxStep(input logic b);
    rxEn = 1'b1; rxBit = b;
    @(negedge clk);
    rxEn = 1'b0;
  endtask

  task automatic doLatch();
    latchStrb = 1'b1;
    @(negedge clk);
    latchStrb = 1'b0;
  endtask

  // send n reference bits, inverting those whose window offset is in [eLo, eHi]
  task automatic rxRun(input int n, input int eLo, input int eHi);
    logic b;
    for (int k = 0; k < n; k++) begin
      mStep(patSel == 2'd1, b);
      rxStep(b ^ (k >= eLo && k <= eHi));
    end
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 txBit", txBit, 0);
    check("R12 inSync", inSync, 0);
    check("R12 errCount", errCount, 0);
    rstN = 1'b1;
  endtask

  task automatic t_prbs(input logic p23, input string req);
    logic b, m;
    int bad = 0;
    doReset();
    patSel = p23 ? 2'd1 : 2'd0;
    for (int k = 0; k < 200; k++) begin
      txStep(b); mStep(p23, m);
      if (b != m) bad++;
    end
    check(req, bad, 0);
  endtask

  task automatic t_gaps();
    logic b, m, held;
    int bad = 0, moved = 0;
    doReset();
    patSel = 2'd0;
    for (int k = 0; k < 30; k++) begin
      txStep(b); mStep(1'b0, m);
      if (b != m) bad++;
      held = txBit;
      repeat (k % 4) begin
        @(negedge clk);
        if (txBit != held) moved++;
      end
    end
    check("R11 sequence across gaps", bad, 0);
    check("R11 txBit held without enable", moved, 0);
  endtask

  task automatic t_user(input logic [31:0] pat, input logic [4:0] len);
    logic b;
    int bad = 0;
    doReset();
    patSel = 2'd2; userPat = pat; userLen = len;
    for (int k = 0; k < 70; k++) begin
      txStep(b);
      if (b != pat[k % (int'(len) + 1)]) bad++;
    end
    check("R3 user word", bad, 0);
  endtask

  task automatic t_single();
    logic b, m;
    int bad = 0;
    doReset();
    patSel = 2'd0;
    for (int k = 0; k < 5; k++) begin txStep(b); mStep(0, m); end
    injOne = 1'b1; @(negedge clk); injOne = 1'b0;
    repeat (2) @(negedge clk);
    txStep(b); mStep(0, m);
    check("R4 next bit inverted", b, !m);
    for (int k = 0; k < 20; k++) begin
      txStep(b); mStep(0, m);
      if (b != m) bad++;
    end
    check("R4 only one inversion", bad, 0);
  endtask

  task automatic t_rate(input logic [2:0] n, input int period, input int len);
    logic b, m;
    int bad = 0;
    doReset();
    patSel = 2'd0; rateSel = n;
    for (int k = 1; k <= len; k++) begin
      txStep(b); mStep(0, m);
      if ((b != m) != (k % period == 0)) bad++;
    end
    rateSel = 3'd0;
    check("R5 rate injection positions", bad, 0);
  endtask

  task automatic t_sync();
    doReset();
    patSel = 2'd0;
    rxRun(31, -1, -1);
    check("R6 no sync after 31 bits", inSync, 0);
    rxRun(1, -1, -1);
    check("R6 sync after 32 bits", inSync, 1);
  endtask

  task automatic t_count();
    logic b;
    doReset();
    patSel = 2'd0;
    rxRun(8, 0, 7);
    rxRun(80, -1, -1);
    check("R6 sync after hunt errors", inSync, 1);
    doLatch();
    check("R8 hunt mismatches not counted", errCount, 0);
    rxRun(20, 5, 7);
    doLatch();
    check("R8 in-sync errors counted", errCount, 3);
    mStep(0, b);
    latchStrb = 1'b1;
    rxStep(!b);
    latchStrb = 1'b0;
    check("R10 latch copies prior count", errCount, 0);
    rxRun(10, -1, -1);
    doLatch();
    check("R10 coincident error kept", errCount, 1);
  endtask

  task automatic t_loss();
    doReset();
    patSel = 2'd0;
    rxRun(32, -1, -1);
    check("R6 sync", inSync, 1);
    rxRun(64, 10, 14);
    check("R7 five errors keep sync", inSync, 1);
    rxRun(11, 6, 10);
    check("R7 still in sync at fifth error", inSync, 1);
    rxRun(1, 0, 0);
    check("R7 sixth error in window drops sync", inSync, 0);
    doLatch();
    check("R8 losing bit counted", errCount, 11);
    rxRun(10, 0, 9);
    doLatch();
    check("R8 no count while hunting", errCount, 0);
  endtask

  task automatic t_sat();
    doReset();
    patSel = 2'd0;
    rxRun(32, -1, -1);
    rxRun(64, 59, 63);
    rxRun(64, 0, 4);
    check("R7 errors across window edge keep sync", inSync, 1);
    rxRun(64, 20, 24);
    rxRun(64, 40, 44);
    doLatch();
    check("R9 wide counter", errCount, 20);
    check("R9 narrow counter saturates", errCountS, 15);
  endtask

  task automatic t_user_rx();
    logic [31:0] pat = 32'h0000_004E;
    doReset();
    patSel = 2'd2; userPat = pat; userLen = 5'd6;
    for (int k = 0; k < 120; k++) rxStep(pat[(k + 3) % 7]);
    check("R3 checker aligns to shifted phase", inSync, 1);
    doLatch();
    check("R3 no errors once aligned", errCount, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_prbs(1'b0, "R1 PRBS15 sequence");
    t_prbs(1'b1, "R2 PRBS23 sequence");
    t_gaps();
    t_user(32'hA5C3_0F96, 5'd4);
    t_user(32'h1234_ABCD, 5'd31);
    t_user(32'h0000_0001, 5'd0);
    t_single();
    t_rate(3'd1, 10, 45);
    t_rate(3'd2, 100, 250);
    t_sync();
    t_count();
    t_loss();
    t_sat();
    t_user_rx();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule